// File: doc/BRIEF.md
# Key-Unlocked Commit-Gated Port Configuration Registers

This block holds the configuration registers of an 8-bit port controller behind a small memory-mapped register bus. Most of the registers are plain storage. One of them, the alternate-function select, is guarded by two further registers. A lock register holds a locked flag. A commit mask, writable only while the port is unlocked, decides which bits of the alternate-function select a write may change.

Software first writes a fixed 32-bit key to the lock register to unlock the port. It then loads the commit mask and relocks with any other value. From then on, writes to the alternate-function select reach only the committed bit positions. The block decodes its own 12-bit byte offsets. It returns twelve identification bytes from the top of its window. Any access to the reserved window below those bytes raises a one-cycle error pulse.

The bus has a single-cycle write strobe, and read data is combinational from the offset.

Top module: `portcfg_lockcommit`

## Requirements
- R1: A write of exactly 0x0ACCE551 to the lock register (offset 0x520) clears the locked flag on the next clock edge. A write of any other value there sets it.
- R2: A read of offset 0x520 returns 1 while the port is locked and 0 while it is unlocked, with all upper bits zero.
- R3: A write to the commit register (offset 0x524) stores bits 7:0 of the write data only while the port is unlocked. While locked the write leaves the register unchanged. A read of 0x524 returns the mask zero-extended.
- R4: A write to the alternate-function select (offset 0x420) changes only the bit positions that are 1 in the commit mask. Every other bit keeps its previous value. A read of 0x420 returns the register zero-extended.
- R5: After reset the port is locked and the commit mask is 0xFF. The configuration register at offset 0x500 (2 mA drive select) reads 0xFF. The alternate-function select and the configuration registers at 0x504 to 0x51C read 0.
- R6: The eight configuration registers at offsets 0x500 + 4*i (i = 0..7) store bits 7:0 of any write and read them back zero-extended. Writes are not gated by the lock or commit state.
- R7: A read of offset 0xFD0 + 4*k (k = 0..11) returns identification byte k, which is bits 8k+7:8k of the identification parameter (default 96'h9E472BD103001C7261000000), zero-extended. Writes to those offsets change nothing.
- R8: An access to any offset from the reserved start parameter (default 0x52C) through 0xFCC drives the error output high in the same cycle the access is presented. Such a read returns 0, and such a write changes no register. The error output is low for every other access and when there is no access.
- R9: A read of an offset outside every mapped register and outside the reserved window (for example 0x528 or 0x000) returns 0 without an error.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous active-low reset |
| busSel | input | 1 | An access is presented this cycle |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | 12 | Byte offset of the access |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Combinational read data, zero when not reading |
| busErr | output | 1 | Error pulse for a reserved-window access |

## Verification
The bench tries a commit write while locked and an unlock with a key that is wrong in one bit. A design that compared fewer key bits, or ignored the lock, would show a changed mask on read-back. It writes the alternate-function select under sparse and dense commit masks, with both all-ones and all-zero data. A design that skipped the mask, or cleared the bits outside it, would read back the wrong pattern. It also probes both ends of the reserved window and the unmapped offset next to it. A decode off by one word would raise the error on the wrong offset, or let a reserved write land in a register.

// File: rtl/portcfg_pkg.sv
package portcfg_pkg;

  localparam int CFG_COUNT = 8;
  localparam int CFG_IDX_W = $clog2(CFG_COUNT);
  localparam int ID_COUNT  = 12;

  localparam logic [11:0] OFS_ALT      = 12'h420;
  localparam logic [11:0] OFS_CFG_BASE = 12'h500;
  localparam logic [11:0] OFS_LOCK     = 12'h520;
  localparam logic [11:0] OFS_COMMIT   = 12'h524;
  localparam logic [11:0] OFS_RSVD_END = 12'hFCC;
  localparam logic [11:0] OFS_ID_BASE  = 12'hFD0;

  localparam logic [31:0] UNLOCK_KEY   = 32'h0ACC_E551;

  typedef enum logic [2:0] {
    RD_ZERO,
    RD_LOCK,
    RD_COMMIT,
    RD_ALT,
    RD_CFG,
    RD_ID
  } rdKind_e;

  typedef struct packed {
    logic                 wrLock;
    logic                 wrCommit;
    logic                 wrAlt;
    logic [CFG_COUNT-1:0] wrCfg;
    rdKind_e              rdKind;
    logic [CFG_IDX_W-1:0] cfgIdx;
    logic [3:0]           idIdx;
    logic                 err;
  } strobes_t;

endpackage

// File: rtl/portcfg_ctrl.sv
module portcfg_ctrl
  import portcfg_pkg::*;
#(
  parameter logic [11:0] RSVD_START = 12'h52C
) (
  input  logic        busSel,
  input  logic        busWrite,
  input  logic [11:0] busAddr,
  output strobes_t    st
);

  localparam logic [11:0] CFG_SPAN = 12'(CFG_COUNT * 4);

  logic [11:0] wordAddr;
  logic [11:0] cfgOfs;
  logic [11:0] idOfs;
  logic        rsvdHit;
  logic        idHit;
  logic        cfgHit;
  logic        doWrite;
  logic        doRead;

  assign wordAddr = {busAddr[11:2], 2'b00};
  assign cfgOfs   = wordAddr - OFS_CFG_BASE;
  assign idOfs    = wordAddr - OFS_ID_BASE;
  assign rsvdHit  = (busAddr >= RSVD_START) && (busAddr <= OFS_RSVD_END);
  assign idHit    = (wordAddr >= OFS_ID_BASE);
  assign cfgHit   = (wordAddr >= OFS_CFG_BASE) && (cfgOfs < CFG_SPAN);
  assign doWrite  = busSel && busWrite;
  assign doRead   = busSel && !busWrite;

  always_comb begin
    st          = '0;
    st.rdKind   = RD_ZERO;
    st.cfgIdx   = cfgOfs[CFG_IDX_W+1:2];
    st.idIdx    = idOfs[5:2];
    if (busSel && rsvdHit) begin
      st.err = 1'b1;
    end else if (idHit) begin
      if (doRead) st.rdKind = RD_ID;
    end else if (cfgHit) begin
      if (doRead) st.rdKind = RD_CFG;
      for (int i = 0; i < CFG_COUNT; i++) begin
        st.wrCfg[i] = doWrite && (st.cfgIdx == CFG_IDX_W'(i));
      end
    end else begin
      unique case (wordAddr)
        OFS_LOCK: begin
          st.wrLock = doWrite;
          if (doRead) st.rdKind = RD_LOCK;
        end
        OFS_COMMIT: begin
          st.wrCommit = doWrite;
          if (doRead) st.rdKind = RD_COMMIT;
        end
        OFS_ALT: begin
          st.wrAlt = doWrite;
          if (doRead) st.rdKind = RD_ALT;
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/portcfg_dpath.sv
module portcfg_dpath
  import portcfg_pkg::*;
#(
  parameter int                      PORT_W   = 8,
  parameter logic [8*ID_COUNT-1:0]   ID_BYTES = 96'h9E472BD103001C7261000000
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          st,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output logic              lockedQ,
  output logic [PORT_W-1:0] commitQ,
  output logic [PORT_W-1:0] altQ
);

  logic [PORT_W-1:0] wrBits;
  logic [PORT_W-1:0] cfgQ [CFG_COUNT];
  logic [7:0]        idByte;

  assign wrBits = wdata[PORT_W-1:0];

  // Lock flag: only the exact key clears it.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          lockedQ <= 1'b1;
    else if (st.wrLock) lockedQ <= (wdata != UNLOCK_KEY);
  end

  // Commit mask: frozen while locked.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                        commitQ <= '1;
    else if (st.wrCommit && !lockedQ) commitQ <= wrBits;
  end

  // Alternate-function select: per-bit gated by the commit mask.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         altQ <= '0;
    else if (st.wrAlt) altQ <= (altQ & ~commitQ) | (wrBits & commitQ);
  end

  for (genvar gi = 0; gi < CFG_COUNT; gi++) begin : g_cfg
    localparam logic [PORT_W-1:0] RST_VAL = (gi == 0) ? '1 : '0;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)             cfgQ[gi] <= RST_VAL;
      else if (st.wrCfg[gi]) cfgQ[gi] <= wrBits;
    end
  end

  assign idByte = ID_BYTES[{st.idIdx, 3'b000} +: 8];

  always_comb begin
    unique case (st.rdKind)
      RD_LOCK:   rdata = {31'b0, lockedQ};
      RD_COMMIT: rdata = 32'(commitQ);
      RD_ALT:    rdata = 32'(altQ);
      RD_CFG:    rdata = 32'(cfgQ[st.cfgIdx]);
      RD_ID:     rdata = (st.idIdx < 4'(ID_COUNT)) ? 32'(idByte) : 32'b0;
      default:   rdata = 32'b0;
    endcase
  end

endmodule

// File: rtl/portcfg_lockcommit.sv
module portcfg_lockcommit
  import portcfg_pkg::*;
#(
  parameter int                    PORT_W     = 8,
  parameter logic [11:0]           RSVD_START = 12'h52C,
  parameter logic [8*ID_COUNT-1:0] ID_BYTES   = 96'h9E472BD103001C7261000000
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        busSel,
  input  logic        busWrite,
  input  logic [11:0] busAddr,
  input  logic [31:0] busWdata,
  output logic [31:0] busRdata,
  output logic        busErr
);

  strobes_t          st;
  logic              lockedQ;
  logic [PORT_W-1:0] commitQ;
  logic [PORT_W-1:0] altQ;

  portcfg_ctrl #(
    .RSVD_START (RSVD_START)
  ) u_ctrl (
    .busSel   (busSel),
    .busWrite (busWrite),
    .busAddr  (busAddr),
    .st       (st)
  );

  portcfg_dpath #(
    .PORT_W   (PORT_W),
    .ID_BYTES (ID_BYTES)
  ) u_dpath (
    .clk     (clk),
    .rstN    (rstN),
    .st      (st),
    .wdata   (busWdata),
    .rdata   (busRdata),
    .lockedQ (lockedQ),
    .commitQ (commitQ),
    .altQ    (altQ)
  );

  assign busErr = st.err;

endmodule

// File: rtl/portcfg_guard_chk.sv
module portcfg_guard_chk
  import portcfg_pkg::*;
#(
  parameter int          PORT_W     = 8,
  parameter logic [11:0] RSVD_START = 12'h52C
) (
  input logic              clk,
  input logic              rstN,
  input logic              busSel,
  input logic              busWrite,
  input logic [11:0]       busAddr,
  input logic [31:0]       busWdata,
  input logic [31:0]       busRdata,
  input logic              busErr,
  input logic              lockedQ,
  input logic [PORT_W-1:0] commitQ,
  input logic [PORT_W-1:0] altQ
);

  logic rsvdAcc;
  logic lockWr;
  logic lockRd;
  logic commitWr;
  logic altWr;

  assign rsvdAcc  = busSel && (busAddr >= RSVD_START) && (busAddr <= OFS_RSVD_END);
  assign lockWr   = busSel && busWrite && (busAddr == OFS_LOCK);
  assign lockRd   = busSel && !busWrite && (busAddr == OFS_LOCK);
  assign commitWr = busSel && busWrite && (busAddr == OFS_COMMIT);
  assign altWr    = busSel && busWrite && (busAddr == OFS_ALT);

  AST_LOCK_KEY: assert property (@(posedge clk) disable iff (!rstN)
    lockWr |=> (lockedQ == ($past(busWdata) != UNLOCK_KEY))); // R1

  AST_LOCK_READ: assert property (@(posedge clk) disable iff (!rstN)
    lockRd |-> (busRdata == {31'b0, lockedQ})); // R2

  AST_COMMIT_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    (commitWr && lockedQ) |=> $stable(commitQ)); // R3

  AST_ALT_MASKED: assert property (@(posedge clk) disable iff (!rstN)
    altWr |=> (((altQ ^ $past(altQ)) & ~$past(commitQ)) == '0)); // R4

  AST_RSVD_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    rsvdAcc |-> (busErr && (busRdata == 32'b0))); // R8

  AST_RSVD_NOWRITE: assert property (@(posedge clk) disable iff (!rstN)
    (rsvdAcc && busWrite) |=> ($stable(lockedQ) && $stable(commitQ) && $stable(altQ))); // R8

  AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !rsvdAcc |-> !busErr); // R8

endmodule

bind portcfg_lockcommit portcfg_guard_chk #(
  .PORT_W     (PORT_W),
  .RSVD_START (RSVD_START)
) u_guard_chk (
  .clk      (clk),
  .rstN     (rstN),
  .busSel   (busSel),
  .busWrite (busWrite),
  .busAddr  (busAddr),
  .busWdata (busWdata),
  .busRdata (busRdata),
  .busErr   (busErr),
  .lockedQ  (lockedQ),
  .commitQ  (commitQ),
  .altQ     (altQ)
);

// File: tb/test_portcfg_lockcommit.sv
module test_portcfg_lockcommit;

  localparam int          CLK_PERIOD = 10;
  localparam logic [11:0] RSVD_START = 12'h52C;
  localparam logic [95:0] ID_BYTES   = 96'h9E472BD103001C7261000000;
  localparam logic [31:0] KEY        = 32'h0ACCE551;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busSel = 1'b0;
  logic        busWrite = 1'b0;
  logic [11:0] busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        busErr;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  typedef struct {
    logic [11:0] addr;
    bit          chkData;
    logic [31:0] data;
    bit          err;
    string       tag;
  } item_t;

  item_t expQ[$];

  // Reference model built from the requirements
  bit         mLocked;
  logic [7:0] mCommit;
  logic [7:0] mAlt;
  logic [7:0] mCfg [8];

  always #(CLK_PERIOD/2) clk = ~clk;

  portcfg_lockcommit i_portcfg_lockcommit (
    .clk      (clk),
    .rstN     (rstN),
    .busSel   (busSel),
    .busWrite (busWrite),
    .busAddr  (busAddr),
    .busWdata (busWdata),
    .busRdata (busRdata),
    .busErr   (busErr)
  );

  function automatic bit isRsvd(input logic [11:0] a);
    return (a >= RSVD_START) && (a <= 12'hFCC);
  endfunction

  function automatic logic [31:0] expRead(input logic [11:0] a);
    if (isRsvd(a)) return 32'b0;
    if (a >= 12'hFD0) return 32'(ID_BYTES[8*((a - 12'hFD0) >> 2) +: 8]);
    if (a >= 12'h500 && a < 12'h520) return 32'(mCfg[(a - 12'h500) >> 2]);
    case (a)
      12'h520: return {31'b0, mLocked};
      12'h524: return 32'(mCommit);
      12'h420: return 32'(mAlt);
      default: return 32'b0;
    endcase
  endfunction

  task automatic modelWrite(input logic [11:0] a, input logic [31:0] wd);
    if (isRsvd(a) || a >= 12'hFD0) return;
    if (a >= 12'h500 && a < 12'h520) mCfg[(a - 12'h500) >> 2] = wd[7:0];
    else if (a == 12'h520) mLocked = (wd != KEY);
    else if (a == 12'h524) begin
      if (!mLocked) mCommit = wd[7:0];
    end else if (a == 12'h420) mAlt = (mAlt & ~mCommit) | (wd[7:0] & mCommit);
  endtask

  task automatic access(input bit wr, input logic [11:0] a,
                        input logic [31:0] wd, input string tag);
    item_t it;
    @(posedge clk); #1;
    busSel = 1'b1; busWrite = wr; busAddr = a; busWdata = wd;
    it.addr = a; it.chkData = !wr; it.data = expRead(a);
    it.err = isRsvd(a); it.tag = tag;
    expQ.push_back(it);
    if (wr) modelWrite(a, wd);
  endtask

  task automatic rd(input logic [11:0] a, input string tag);
    access(1'b0, a, 32'b0, tag);
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] wd, input string tag);
    access(1'b1, a, wd, tag);
  endtask

  task automatic idle();
    @(posedge clk); #1;
    busSel = 1'b0; busWrite = 1'b0;
  endtask

  // Monitor: pops one expectation per presented access
  always @(negedge clk) begin
    if (rstN && busSel) begin
      item_t it;
      if (expQ.size() == 0) begin
        checks++; errors++;
        $display("FAIL monitor: access with no expectation at addr %h", busAddr);
      end else begin
        it = expQ.pop_front();
        checks++;
        if ((it.chkData && busRdata !== it.data) || busErr !== it.err) begin
          errors++;
          $display("FAIL %s addr=%h rdata actual %h expected %h err actual %b expected %b",
                   it.tag, it.addr, busRdata, it.chkData ? it.data : busRdata,
                   busErr, it.err);
        end
      end
    end
  end

  // No-access cycles must keep the error output low
  always @(negedge clk) begin
    if (rstN && !busSel && busErr !== 1'b0) begin
      checks++; errors++;
      $display("FAIL R8 idle: busErr actual %b expected 0", busErr);
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    mLocked = 1'b1; mCommit = 8'hFF; mAlt = 8'h00;
    for (int i = 0; i < 8; i++) mCfg[i] = (i == 0) ? 8'hFF : 8'h00;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    // R5 reset values (R2 lock read while locked)
    rd(12'h520, "R5_R2 reset lock");
    rd(12'h524, "R5 reset commit");
    rd(12'h420, "R5 reset alt");
    for (int i = 0; i < 8; i++) rd(12'h500 + 12'(4*i), "R5 reset cfg");

    // R4 full commit mask at reset lets every bit through
    wr(12'h420, 32'h0000_00A5, "R4 write under full mask");
    rd(12'h420, "R4 readback full mask");

    // R3 commit write while locked is ignored
    wr(12'h524, 32'h0000_000F, "R3 locked commit write");
    rd(12'h524, "R3 commit unchanged");

    // R1 unlock with key, R2 reads 0
    wr(12'h520, KEY, "R1 unlock key");
    rd(12'h520, "R1_R2 unlocked read");
    wr(12'h524, 32'hFFFF_F13C, "R3 unlocked commit low byte");
    rd(12'h524, "R3 commit stored");

    // R1 relock with a near-miss key
    wr(12'h520, KEY ^ 32'h1, "R1 wrong key");
    rd(12'h520, "R1_R2 relocked");
    wr(12'h524, 32'h0000_0055, "R3 commit after relock");
    rd(12'h524, "R3 commit frozen");

    // R4 masked alternate-function writes
    wr(12'h420, 32'h0000_00FF, "R4 ones under 0x3C");
    rd(12'h420, "R4 readback ones");
    wr(12'h420, 32'h0000_0000, "R4 zeros under 0x3C");
    rd(12'h420, "R4 readback zeros");
    wr(12'h520, KEY, "R1 unlock again");
    wr(12'h524, 32'h0000_0000, "R3 empty mask");
    wr(12'h420, 32'h0000_00FF, "R4 empty mask write");
    rd(12'h420, "R4 readback empty mask");
    wr(12'h524, 32'h0000_0081, "R3 sparse mask");
    wr(12'h420, 32'h0000_0081, "R4 sparse mask write");
    rd(12'h420, "R4 readback sparse mask");

    // R6 plain configuration storage
    for (int i = 0; i < 8; i++) wr(12'h500 + 12'(4*i), 32'hABCD_0000 | 32'(8'h11 * (i + 1)), "R6 cfg write");
    for (int i = 0; i < 8; i++) rd(12'h500 + 12'(4*i), "R6 cfg readback");
    wr(12'h520, 32'h0, "R1 lock with zero");
    wr(12'h504, 32'h0000_005A, "R6 cfg write while locked");
    rd(12'h504, "R6 cfg readback while locked");

    // R7 identification bytes, and writes to them
    for (int k = 0; k < 12; k++) rd(12'hFD0 + 12'(4*k), "R7 id byte");
    wr(12'hFD0, 32'hFFFF_FFFF, "R7 write id");
    rd(12'hFD0, "R7 id unchanged");
    wr(12'hFFC, 32'h0, "R7 write last id");
    rd(12'hFFC, "R7 last id unchanged");

    // R8 reserved window edges and writes
    rd(12'h52C, "R8 reserved low edge");
    rd(12'h800, "R8 reserved middle");
    rd(12'hFCC, "R8 reserved high edge");
    wr(12'h52C, KEY, "R8 reserved write");
    rd(12'h520, "R8 lock untouched by reserved write");
    wr(12'hFCC, 32'hFF, "R8 reserved write high");
    rd(12'h420, "R8 alt untouched");
    rd(12'h524, "R8 commit untouched");

    // R9 unmapped offsets
    rd(12'h528, "R9 unmapped next to reserved");
    rd(12'h000, "R9 unmapped low");
    rd(12'h41C, "R9 unmapped below alt");

    idle();
    repeat (3) @(posedge clk);
    if (expQ.size() != 0) begin
      checks++; errors++;
      $display("FAIL monitor: %0d expectations left, expected 0", expQ.size());
    end
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule